// File: doc/BRIEF.md
# Pin Interrupt Detector

This block watches one already synchronized (and, where wanted, debounced) input line and turns a chosen kind of activity on it into a sticky interrupt status bit. A three-bit sense code picks one of five detection modes: falling edge, rising edge, either edge, low level or high level. An enable bit decides whether detected events may set the status. A mask bit freezes input sampling. A write-one-to-clear strobe drops the status again.

Edges are found by comparing the present input with a registered copy taken on an earlier clock. On the first clock after reset the block only loads that copy from the input, so a line that is already high or low does not look like an edge. The status is held by a two-state machine. In ST_IDLE the status is low. The transition IDLE_TO_PEND fires on an enabled event. ST_PEND holds the status high. The transition PEND_TO_IDLE fires on a clear strobe in a cycle without an enabled event. An enabled event in ST_PEND keeps the machine in ST_PEND, so in the level modes a clear has no lasting effect while the active level persists.

Top module: `pin_irq_detector`

## Requirements
- R1: After reset `irq_status` is 0, and the first clock edge after reset release only loads the reference sample: no event is detected on that edge, whatever the input level.
- R2: With sense code 000 the block detects a falling edge: the input is 0 and the reference sample is 1.
- R3: With sense code 001 the block detects a rising edge: the input is 1 and the reference sample is 0.
- R4: When bit 1 of the sense code is 0 and bit 2 is 1 (codes 100 and 101), either edge is detected.
- R5: When bit 1 of the sense code is 1 and bit 0 is 0 (codes 010 and 110), the block detects a low level on the input in every cycle.
- R6: When bits 1 and 0 of the sense code are both 1 (codes 011 and 111), the block detects a high level in every cycle. While that level persists, the status stays set even through a clear strobe.
- R7: On a clock edge with `clr_strobe` high and no enabled event, the status becomes 0. If an enabled event occurs in the same cycle, the event wins and the status is 1.
- R8: An event sets the status on the clock edge that samples it, but only if `irq_en` is 1. With `irq_en` at 0, events are ignored and an existing status is kept.
- R9: While `in_mask` is 1, the reference sample does not change and no event is detected. After the mask is released, the input is compared with the frozen sample. An edge that happened while masked is therefore seen on the first unmasked edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_filt | input | 1 | Synchronized, filtered line value |
| sense_type | input | 3 | Detection mode code |
| irq_en | input | 1 | Allows events to set the status |
| in_mask | input | 1 | Freezes sampling and suppresses events |
| clr_strobe | input | 1 | Write-one-to-clear pulse for the status |
| irq_status | output | 1 | Sticky interrupt status |

## Verification
An event is combinational between the live input and the stored sample, so the status reflects it after exactly one rising clock edge. The reference sample advances on the same edge. The bench drives every input on the falling edge and compares `irq_status` on the next falling edge, after one rising edge has passed, against its own model of the sample and status. Sweeps cover all eight sense codes with both enable values, while the level, mask and clear patterns are generated. Directed sequences cover priming after reset, clearing during a persistent level, and an edge that occurs while the input is masked.

// File: rtl/pid_pkg.sv
package pid_pkg;
    localparam int TYPE_W = 3;
    localparam int BIT_POL  = 0;
    localparam int BIT_LVL  = 1;
    localparam int BIT_DUAL = 2;

    typedef enum logic [2:0] {
        SENSE_FALL,
        SENSE_RISE,
        SENSE_BOTH,
        SENSE_LOW,
        SENSE_HIGH
    } sense_e;

    typedef enum logic {
        ST_IDLE,
        ST_PEND
    } stat_e;
endpackage

// File: rtl/pid_mode_decode.sv
module pid_mode_decode
    import pid_pkg::*;
(
    input  logic [TYPE_W-1:0] type_code,
    output sense_e            mode
);
    always_comb begin
        if (type_code[BIT_LVL]) begin
            mode = type_code[BIT_POL] ? SENSE_HIGH : SENSE_LOW;
        end else if (type_code[BIT_DUAL]) begin
            mode = SENSE_BOTH;
        end else begin
            mode = type_code[BIT_POL] ? SENSE_RISE : SENSE_FALL;
        end
    end
endmodule

// File: rtl/pid_sampler.sv
module pid_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic mask,
    output logic prev_q,
    output logic primed_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q   <= 1'b0;
            primed_q <= 1'b0;
        end else if (!primed_q) begin
            prev_q   <= pin;
            primed_q <= 1'b1;
        end else if (!mask) begin
            prev_q <= pin;
        end
    end

    // R9
    mask_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask && primed_q) |=> $stable(prev_q));

    // R1
    prime_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q |=> primed_q);
endmodule

// File: rtl/pid_event.sv
module pid_event
    import pid_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  sense_e mode,
    input  logic   pin,
    input  logic   prev,
    input  logic   primed,
    input  logic   mask,
    output logic   fire
);
    logic raw;

    always_comb begin
        unique case (mode)
            SENSE_FALL: raw = prev & ~pin;
            SENSE_RISE: raw = ~prev & pin;
            SENSE_BOTH: raw = prev ^ pin;
            SENSE_LOW:  raw = ~pin;
            SENSE_HIGH: raw = pin;
            default:    raw = 1'b0;
        endcase
        fire = raw & primed & ~mask;
    end

    // R9
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask |-> !fire);

    // R1
    unprimed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !primed |-> !fire);
endmodule

// File: rtl/pid_status_fsm.sv
module pid_status_fsm
    import pid_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic en,
    input  logic clr,
    output logic status
);
    stat_e state_q, state_d;
    logic  hit;

    assign hit = fire & en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (hit) state_d = ST_PEND;
            ST_PEND: if (clr && !hit) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        status = (state_q == ST_PEND);
    end

    // R8
    hit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> status);

    // R7
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit) |=> !status);

    // R8
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!status && !hit) |=> !status);
endmodule

// File: rtl/pin_irq_detector.sv
module pin_irq_detector
    import pid_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_filt,
    input  logic [TYPE_W-1:0] sense_type,
    input  logic              irq_en,
    input  logic              in_mask,
    input  logic              clr_strobe,
    output logic              irq_status
);
    sense_e mode;
    logic   prev_q, primed_q, fire;

    pid_mode_decode u_dec (
        .type_code (sense_type),
        .mode      (mode)
    );

    pid_sampler u_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (pin_filt),
        .mask     (in_mask),
        .prev_q   (prev_q),
        .primed_q (primed_q)
    );

    pid_event u_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .pin    (pin_filt),
        .prev   (prev_q),
        .primed (primed_q),
        .mask   (in_mask),
        .fire   (fire)
    );

    pid_status_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (fire),
        .en     (irq_en),
        .clr    (clr_strobe),
        .status (irq_status)
    );

    // R6
    level_high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && !in_mask && irq_en && sense_type[1] && sense_type[0] && pin_filt)
        |=> irq_status);
endmodule

// File: tb/tb_pin_irq_detector.sv
module tb_pin_irq_detector;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_filt = 1'b0;
    logic [2:0] sense_type = 3'b000;
    logic       irq_en = 1'b0;
    logic       in_mask = 1'b0;
    logic       clr_strobe = 1'b0;
    logic       irq_status;

    int checks = 0;
    int failures = 0;
    logic m_prev = 1'b0;
    logic m_primed = 1'b0;
    logic m_stat = 1'b0;
    logic [7:0] lfsr = 8'hA5;

    always #2.5 clk = ~clk;

    pin_irq_detector dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_filt   (pin_filt),
        .sense_type (sense_type),
        .irq_en     (irq_en),
        .in_mask    (in_mask),
        .clr_strobe (clr_strobe),
        .irq_status (irq_status)
    );

    function automatic string tag_of(input logic [2:0] t);
        if (t[1])      return t[0] ? "R6" : "R5";
        else if (t[2]) return "R4";
        else           return t[0] ? "R3" : "R2";
    endfunction

    task automatic check(input string req, input logic exp);
        checks++;
        if (irq_status !== exp) begin
            failures++;
            $display("FAIL %s: irq_status=%b expected=%b", req, irq_status, exp);
        end
    endtask

    // drive at negedge, one rising edge, compare at next negedge
    task automatic step(input logic p, input logic [2:0] t, input logic en,
                        input logic msk, input logic clr, input string req);
        logic ev;
        pin_filt = p; sense_type = t; irq_en = en; in_mask = msk; clr_strobe = clr;
        @(posedge clk);
        if (!m_primed) begin
            ev = 1'b0; m_prev = p; m_primed = 1'b1;
        end else begin
            if (t[1])      ev = (p == t[0]);
            else if (t[2]) ev = (p != m_prev);
            else if (t[0]) ev = p && !m_prev;
            else           ev = !p && m_prev;
            if (msk) ev = 1'b0;
            else     m_prev = p;
        end
        if (ev && en)  m_stat = 1'b1;
        else if (clr)  m_stat = 1'b0;
        @(negedge clk);
        check(req, m_stat);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        failures++;
        $display("FAIL watchdog: expired expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state, then priming with input already high in rising mode
        pin_filt = 1'b1; sense_type = 3'b001; irq_en = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", 1'b0);
        rst_n = 1'b1;
        step(1'b1, 3'b001, 1'b1, 1'b0, 1'b0, "R1");
        step(1'b1, 3'b001, 1'b1, 1'b0, 1'b0, "R1");
        // R3 then R7 clear
        step(1'b0, 3'b001, 1'b1, 1'b0, 1'b0, "R3");
        step(1'b1, 3'b001, 1'b1, 1'b0, 1'b0, "R3");
        step(1'b1, 3'b001, 1'b1, 1'b0, 1'b1, "R7");
        // R7: event and clear in the same cycle, event wins
        step(1'b0, 3'b000, 1'b1, 1'b0, 1'b1, "R7");
        step(1'b0, 3'b000, 1'b1, 1'b0, 1'b1, "R7");
        // R6: clear while high level persists keeps status
        step(1'b1, 3'b011, 1'b1, 1'b0, 1'b0, "R6");
        step(1'b1, 3'b011, 1'b1, 1'b0, 1'b1, "R6");
        step(1'b0, 3'b011, 1'b1, 1'b0, 1'b1, "R6");
        // R8: disabled events ignored, existing status kept
        step(1'b0, 3'b010, 1'b0, 1'b0, 1'b0, "R8");
        step(1'b1, 3'b001, 1'b1, 1'b0, 1'b0, "R8");
        step(1'b0, 3'b000, 1'b0, 1'b0, 1'b0, "R8");
        step(1'b0, 3'b000, 1'b0, 1'b0, 1'b1, "R7");
        // R9: edge during mask, seen on release
        step(1'b0, 3'b001, 1'b1, 1'b1, 1'b0, "R9");
        step(1'b1, 3'b001, 1'b1, 1'b1, 1'b0, "R9");
        step(1'b1, 3'b011, 1'b1, 1'b1, 1'b0, "R9");
        step(1'b1, 3'b001, 1'b1, 1'b0, 1'b0, "R9");
        step(1'b1, 3'b001, 1'b1, 1'b0, 1'b1, "R7");
        // sweep over every sense code and both enables
        for (int t = 0; t < 8; t++) begin
            for (int e = 0; e < 2; e++) begin
                for (int i = 0; i < 48; i++) begin
                    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                    step(lfsr[0], 3'(t), e[0], (lfsr[3:1] == 3'b000),
                         (lfsr[6:5] == 2'b00), tag_of(3'(t)));
                end
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule